// File: doc/BRIEF.md
# DMA Channel Address and Transfer Sequencer

This block is the control engine of one DMA channel. Each accepted request moves a single data item between a peripheral register space and a local DMA RAM. The block sequences the move as a read strobe and address, then a write strobe and address, and optionally a third strobe that sends a zero-data write to the peripheral. After each item it updates the working RAM address and the remaining item count. When the last item has been moved it raises a one-cycle completion pulse and goes quiet.

Software sets the configuration inputs while the channel is disabled and then enables it. The rising edge of the enable input loads the working RAM address from the start address and loads the item counter. Transfer size, direction and RAM addressing mode decide which address each strobe carries. In peripheral-indirect mode, the requesting peripheral supplies an offset that is ORed into an aligned RAM base.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, and at any time while `en_i` is low, `rd_o`, `wr_o`, `wr_null_o`, `done_o` and `busy_o` are all 0.
- R2: With `cfg_byte_i`=0 (word size), every RAM address driven on a strobe has bit 0 cleared, even when the start address is odd.
- R3: With `cfg_mode_i`=2'b00, the working RAM address advances by 2 after each word item and by 1 after each byte item, starting from `start_addr_i`.
- R4: With `cfg_mode_i`=2'b01 or the reserved value 2'b11, every item uses the same RAM address, which is `start_addr_i` (bit 0 cleared in word mode).
- R5: With `cfg_mode_i`=2'b10, the RAM address of an item is `start_addr_i | pi_offset_i`, with `pi_offset_i` sampled in the cycle the request is accepted. Later changes to the offset have no effect on that item, and no post-increment takes place.
- R6: The peripheral-side address is always `periph_addr_i`, unchanged from item to item.
- R7: The block accepts a request on a clock edge where `req_i`=1 and the channel is ready. `rd_o` is high in the next cycle and `wr_o` in the cycle after that. With `cfg_dir_i`=0 the read targets the peripheral (`rd_ram_o`=0) and the write targets RAM (`wr_ram_o`=1). With `cfg_dir_i`=1 both are reversed.
- R8: With `cfg_nullw_i`=1 and `cfg_dir_i`=0, the cycle after the RAM write carries a further `wr_o` to `periph_addr_i` with `wr_null_o`=1 and `wr_ram_o`=0. With `cfg_dir_i`=1 no such strobe occurs.
- R9: A channel enabled with `count_i`=N moves N+1 items regardless of size. `done_o` pulses for one cycle, in the cycle after the last write strobe of the final item.
- R10: After `done_o`, `busy_o` is 0 and requests produce no strobes until `en_i` goes low and then high again. That re-enable reloads the start address and the count.
- R11: A request that arrives while an item is still in progress is ignored. It is neither queued nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable; a rising edge arms the channel |
| cfg_byte_i | input | 1 | 1 = byte items, 0 = word items |
| cfg_dir_i | input | 1 | 0 = peripheral to RAM, 1 = RAM to peripheral |
| cfg_mode_i | input | 2 | RAM addressing mode (00 post-inc, 01/11 fixed, 10 peripheral-indirect) |
| cfg_nullw_i | input | 1 | Extra zero write to the peripheral on receive |
| start_addr_i | input | AW | RAM start address |
| periph_addr_i | input | AW | Peripheral register address |
| count_i | input | CW | Items to move minus one |
| req_i | input | 1 | Transfer request from the peripheral |
| pi_offset_i | input | AW | Offset supplied by the peripheral in indirect mode |
| busy_o | output | 1 | Channel armed and not yet complete |
| rd_o | output | 1 | Read strobe |
| rd_ram_o | output | 1 | Read targets RAM (1) or peripheral (0) |
| rd_addr_o | output | AW | Read address |
| wr_o | output | 1 | Write strobe |
| wr_ram_o | output | 1 | Write targets RAM (1) or peripheral (0) |
| wr_null_o | output | 1 | Write carries zero data |
| wr_addr_o | output | AW | Write address |
| xfer_byte_o | output | 1 | Size of the current item |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the peripheral-indirect offset being captured in exactly the accept cycle. Reaching it needs an offset that changes the cycle after the request, while the item is still in flight. The driver therefore drives a different, conflicting offset on the cycle after each request in that mode. A second hard case is a request landing inside a running item. The driver holds `req_i` high for two cycles on selected items, so the second cycle falls in the read phase. Any extra read or write that this produced would show up as an unexpected item at the monitor. The final subtle case is the halted state after completion. Stray requests are sent there, and the scoreboard must see no strobes before a re-enable proves that the address and count reload.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    AM_POSTINC = 2'b00,
    AM_FIXED   = 2'b01,
    AM_PERIND  = 2'b10,
    AM_RSVD    = 2'b11
  } amode_e;

  typedef enum logic [2:0] {
    PH_OFF,
    PH_READY,
    PH_RD,
    PH_WR,
    PH_NULL,
    PH_UPD,
    PH_HALT
  } phase_e;
endpackage

// File: rtl/dma_phase_fsm.sv
module dma_phase_fsm
  import dma_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   req_i,
  input  logic   null_en_i,
  input  logic   last_i,
  output phase_e phase_o,
  output logic   load_o,
  output logic   accept_o,
  output logic   upd_o,
  output logic   done_o
);
  phase_e st_q, st_d;
  logic   en_q;

  assign load_o   = en_i & ~en_q;
  assign accept_o = en_i & (st_q == PH_READY) & req_i;
  assign upd_o    = en_i & (st_q == PH_UPD);
  assign done_o   = upd_o & last_i;
  assign phase_o  = st_q;

  always_comb begin
    st_d = st_q;
    if (!en_i) st_d = PH_OFF;
    else begin
      unique case (st_q)
        PH_OFF:   if (load_o) st_d = PH_READY;
        PH_READY: if (req_i) st_d = PH_RD;
        PH_RD:    st_d = PH_WR;
        PH_WR:    st_d = null_en_i ? PH_NULL : PH_UPD;
        PH_NULL:  st_d = PH_UPD;
        PH_UPD:   st_d = last_i ? PH_HALT : PH_READY;
        PH_HALT:  st_d = PH_HALT;
        default:  st_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PH_OFF;
      en_q <= 1'b0;
    end else begin
      st_q <= st_d;
      en_q <= en_i;
    end
  end

  AST_RD_FOLLOWS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> st_q == PH_RD) else $error("accept not followed by read"); // R7
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_HALT) && en_i |=> st_q == PH_HALT) else $error("halt left while enabled"); // R10
endmodule

// File: rtl/dma_ram_addr.sv
module dma_ram_addr
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          accept_i,
  input  logic          upd_i,
  input  logic          byte_i,
  input  amode_e        mode_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] offs_i,
  output logic [AW-1:0] eff_o
);
  logic [AW-1:0] addr_q, offs_q, raw, step;

  assign step = byte_i ? AW'(1) : AW'(2);
  assign raw  = (mode_i == AM_PERIND) ? (start_i | offs_q) : addr_q;
  assign eff_o = byte_i ? raw : {raw[AW-1:1], 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      offs_q <= '0;
    end else begin
      if (load_i) addr_q <= start_i;
      else if (upd_i && mode_i == AM_POSTINC) addr_q <= addr_q + step;
      if (accept_i) offs_q <= offs_i;
    end
  end

  AST_POSTINC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !load_i && mode_i == AM_POSTINC |=> addr_q == $past(addr_q) + $past(step))
    else $error("post-increment step wrong"); // R3
  AST_FIXED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i && !load_i && mode_i != AM_POSTINC |=> $stable(addr_q))
    else $error("address moved in fixed mode"); // R4
endmodule

// File: rtl/dma_item_cnt.sv
module dma_item_cnt #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          dec_i,
  input  logic [CW-1:0] count_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= count_i;
    else if (dec_i && !last_o) cnt_q <= cnt_q - 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !load_i && !last_o |=> cnt_q == $past(cnt_q) - 1'b1)
    else $error("count step wrong"); // R9
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cfg_byte_i,
  input  logic          cfg_dir_i,
  input  logic [1:0]    cfg_mode_i,
  input  logic          cfg_nullw_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] periph_addr_i,
  input  logic [CW-1:0] count_i,
  input  logic          req_i,
  input  logic [AW-1:0] pi_offset_i,
  output logic          busy_o,
  output logic          rd_o,
  output logic          rd_ram_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_o,
  output logic          wr_ram_o,
  output logic          wr_null_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          xfer_byte_o,
  output logic          done_o
);
  phase_e        phase;
  logic          load, accept, upd, last;
  logic [AW-1:0] ram_addr;
  amode_e        mode;

  assign mode = amode_e'(cfg_mode_i);

  dma_phase_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .req_i    (req_i),
    .null_en_i(cfg_nullw_i & ~cfg_dir_i),
    .last_i   (last),
    .phase_o  (phase),
    .load_o   (load),
    .accept_o (accept),
    .upd_o    (upd),
    .done_o   (done_o)
  );

  dma_ram_addr #(.AW(AW)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .accept_i(accept),
    .upd_i   (upd),
    .byte_i  (cfg_byte_i),
    .mode_i  (mode),
    .start_i (start_addr_i),
    .offs_i  (pi_offset_i),
    .eff_o   (ram_addr)
  );

  dma_item_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dec_i  (upd),
    .count_i(count_i),
    .last_o (last)
  );

  logic in_xfer;
  assign in_xfer = en_i & (phase inside {PH_READY, PH_RD, PH_WR, PH_NULL, PH_UPD});

  assign busy_o      = in_xfer;
  assign xfer_byte_o = cfg_byte_i;
  assign rd_o        = en_i & (phase == PH_RD);
  assign rd_ram_o    = cfg_dir_i;
  assign rd_addr_o   = cfg_dir_i ? ram_addr : periph_addr_i;
  assign wr_o        = en_i & (phase inside {PH_WR, PH_NULL});
  assign wr_null_o   = en_i & (phase == PH_NULL);
  assign wr_ram_o    = (phase == PH_WR) & ~cfg_dir_i;
  assign wr_addr_o   = wr_ram_o ? ram_addr : periph_addr_i;

  AST_RD_THEN_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o && en_i |=> !en_i || (wr_o && !wr_null_o)) else $error("read not followed by write"); // R7
  AST_NULL_RX_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_null_o |-> !cfg_dir_i && !wr_ram_o && wr_o) else $error("null write misplaced"); // R8
  AST_WORD_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_byte_i && ((rd_o && rd_ram_o) || (wr_o && wr_ram_o)) |-> ram_addr[0] == 1'b0)
    else $error("odd word address"); // R2
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !rd_o) else $error("activity after done"); // R10
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !rd_o && !wr_o && !busy_o && !done_o) else $error("activity while disabled"); // R1
endmodule

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  localparam int AW = 16;
  localparam int CW = 10;

  typedef struct {
    int          kind;   // 0 read, 1 write, 2 done
    bit          ram;
    bit          nul;
    logic [15:0] addr;
    string       tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic en = 0, cfg_byte = 0, cfg_dir = 0, cfg_nullw = 0, req = 0;
  logic [1:0] cfg_mode = 0;
  logic [AW-1:0] start_addr = 0, periph_addr = 0, pi_off = 0;
  logic [CW-1:0] count = 0;
  logic busy, rd, rd_ram, wr, wr_ram, wr_null, xbyte, done;
  logic [AW-1:0] rd_addr, wr_addr;

  int total = 0, bad = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  dma_chan_seq #(.AW(AW), .CW(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cfg_byte_i(cfg_byte), .cfg_dir_i(cfg_dir),
    .cfg_mode_i(cfg_mode), .cfg_nullw_i(cfg_nullw), .start_addr_i(start_addr),
    .periph_addr_i(periph_addr), .count_i(count), .req_i(req), .pi_offset_i(pi_off),
    .busy_o(busy), .rd_o(rd), .rd_ram_o(rd_ram), .rd_addr_o(rd_addr), .wr_o(wr),
    .wr_ram_o(wr_ram), .wr_null_o(wr_null), .wr_addr_o(wr_addr), .xfer_byte_o(xbyte),
    .done_o(done)
  );

  task automatic check(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: pops one expected item per observed event
  always @(negedge clk) begin
    if (rst_n && (rd || wr || done)) begin
      int kind;
      bit ram, nul;
      logic [15:0] addr;
      kind = done ? 2 : (rd ? 0 : 1);
      ram  = rd ? rd_ram : wr_ram;
      nul  = wr_null;
      addr = rd ? rd_addr : wr_addr;
      if (exp_q.size() == 0) begin
        check(0, "R10/R11", "unexpected event kind", kind, 99);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(kind == e.kind, e.tag, "event kind", kind, e.kind);
        if (kind == e.kind && kind != 2) begin
          check(ram == e.ram, e.tag, "ram side", int'(ram), int'(e.ram));
          check(nul == e.nul, e.tag, "null flag", int'(nul), int'(e.nul));
          check(addr == e.addr, e.tag, "address", int'(addr), int'(e.addr));
        end
      end
    end
  end

  task automatic push(int kind, bit ram, bit nul, logic [15:0] addr, string tag);
    item_t e;
    e.kind = kind; e.ram = ram; e.nul = nul; e.addr = addr; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R7", "pending items", exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic run_chan(bit b, bit dir, logic [1:0] mode, bit nw, logic [15:0] st,
                          logic [15:0] pad, int n, logic [15:0] off0, bit dbl_req, string tag);
    logic [15:0] wa, ra;
    @(negedge clk);
    en = 0;
    cfg_byte = b; cfg_dir = dir; cfg_mode = mode; cfg_nullw = nw;
    start_addr = st; periph_addr = pad; count = CW'(n - 1);
    @(negedge clk);
    en = 1;
    @(negedge clk);
    check(busy == 1, "R10", "busy after enable", int'(busy), 1);
    wa = st;
    for (int i = 0; i < n; i++) begin
      logic [15:0] off;
      off = off0 + 16'(i * 3);
      ra = (mode == 2'b10) ? (st | off) : wa;
      if (!b) ra[0] = 1'b0;
      if (dir) begin
        push(0, 1, 0, ra, tag);
        push(1, 0, 0, pad, "R6");
      end else begin
        push(0, 0, 0, pad, "R6");
        push(1, 1, 0, ra, tag);
        if (nw) push(1, 0, 1, pad, "R8");
      end
      if (i == n - 1) push(2, 0, 0, 0, "R9");
      if (mode == 2'b00) wa = wa + (b ? 16'd1 : 16'd2);
      req = 1; pi_off = off;
      @(negedge clk);
      if (!dbl_req) req = 0;
      pi_off = ~off;  // conflicting value after accept
      @(negedge clk);
      req = 0;
      wait_drain();
    end
    check(busy == 0, "R10", "busy after done", int'(busy), 0);
  endtask

  initial begin
    int wd;
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        check(0, "WDOG", "watchdog expired", wd, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !rd && !wr && !done, "R1", "idle in reset", int'({busy, rd, wr, done}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && !rd && !wr && !done, "R1", "idle disabled", int'({busy, rd, wr, done}), 0);

    run_chan(0, 0, 2'b00, 0, 16'h0041, 16'h0300, 3, 0, 0, "R2");  // word post-inc, odd start
    run_chan(1, 1, 2'b00, 0, 16'h0013, 16'h0302, 3, 0, 0, "R3");  // byte post-inc, tx
    run_chan(0, 1, 2'b01, 0, 16'h0020, 16'h0304, 3, 0, 1, "R4");  // fixed, double req
    run_chan(1, 0, 2'b11, 0, 16'h0027, 16'h0306, 2, 0, 0, "R4");  // reserved = fixed
    run_chan(1, 0, 2'b10, 0, 16'h0080, 16'h0308, 3, 16'h05, 0, "R5");
    run_chan(0, 1, 2'b10, 0, 16'h0100, 16'h030A, 2, 16'h07, 1, "R5");
    run_chan(0, 0, 2'b00, 1, 16'h0200, 16'h030C, 3, 0, 1, "R8");  // null write on receive
    run_chan(1, 1, 2'b00, 1, 16'h0210, 16'h030E, 2, 0, 0, "R8");  // no null on transmit

    // stray requests after completion must be ignored (R10)
    for (int i = 0; i < 3; i++) begin
      req = 1; @(negedge clk); req = 0; @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check(busy == 0, "R10", "halted busy", int'(busy), 0);

    // re-enable reloads start and count (R10)
    run_chan(1, 1, 2'b00, 1, 16'h0210, 16'h030E, 2, 0, 0, "R10");
    run_chan(0, 0, 2'b00, 0, 16'h0400, 16'h0310, 1, 0, 0, "R9");

    @(negedge clk);
    en = 0;
    @(negedge clk);
    check(!busy && !rd && !wr, "R1", "disabled idle", int'({busy, rd, wr}), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule